// File: doc/BRIEF.md
# Isolation Ordering Monitor

This block watches the power controls of one switchable domain and the values that domain presents to always-on logic through its isolation clamps. It changes nothing: every input is only observed. It catches four kinds of fault. Isolation can arrive too late, after the domain is already being switched off. Isolation can be lifted too soon, before the domain has finished powering back up. Isolation can drop while the domain is still off. Finally, a clamped value can differ from the agreed safe value while the domain is off, which means corruption is leaking through.

Power-up counts as complete only once the switch acknowledge has been high, together with the switch enable, for `SETTLE_CYC` consecutive sampled clock edges. Each fault class keeps a sticky flag, raises a one-cycle pulse for every new occurrence, and counts its occurrences in a saturating counter. A single-cycle clear pulse resets all flags and counters. All ports are plain level signals, because no data stream passes through the block. The first clock edge after reset only captures the inputs, so no edge is inferred from the reset state.

Top module: `iso_order_mon`

## Requirements
- R1: During and just after reset, `err_flags_o`, `err_pulse_o` and `err_cnt_o` are all zero.
- R2: If `pwr_en_i` goes from 1 to 0 at a sampled edge while `iso_en_i` is 0, a late-isolation fault is raised on class bit 0.
- R3: If `iso_en_i` goes from 1 to 0 while `pwr_en_i` is 1, but `pwr_ack_i` has not yet been high with `pwr_en_i` for `SETTLE_CYC` consecutive edges before that edge, an early-release fault is raised on class bit 1.
- R4: If `iso_en_i` goes from 1 to 0 while `pwr_en_i` is 0, a drop-while-off fault is raised on class bit 2.
- R5: While `pwr_en_i` is 0, an `iso_out_i` value that differs from `CLAMP_VAL` is a leak on class bit 3. A run of consecutive mismatching edges counts as one event.
- R6: Flags are sticky until `clr_i` is sampled high. `clr_i` zeroes every flag and counter, but an event on the same edge sets its flag and leaves its counter at 1.
- R7: Each event raises `err_pulse_o[k]` for exactly the one cycle after the edge on which it was sampled, and the flag sets in that same cycle.
- R8: Counter k sits in `err_cnt_o[8k+7:8k]`, adds one per event, and saturates at 255.
- R9: An ordered sequence (isolation on before power-off, release only after settling) raises nothing. The first edge after reset raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iso_en_i | input | 1 | Isolation enable of the domain (1 = clamping) |
| pwr_en_i | input | 1 | Power-switch enable (1 = domain on) |
| pwr_ack_i | input | 1 | Power-switch acknowledge |
| iso_out_i | input | DATA_W | Clamped view of the domain outputs on the always-on side |
| clr_i | input | 1 | Single-cycle clear of flags and counters |
| err_flags_o | output | 4 | Sticky flags: bit0 late, bit1 early, bit2 drop-while-off, bit3 leak |
| err_pulse_o | output | 4 | One-cycle event pulses, same bit order |
| err_cnt_o | output | 32 | Four saturating 8-bit counters, class k in bits 8k+7:8k |

## Verification
The assertions check the following on every cycle. The settle counter must fall back once power or acknowledge drops. Early release and drop-while-off can never fire together. Each detector must fire on its ordering condition. A pulse always comes with its flag, a flag holds until a clear, and a full counter stays full. The bench scenarios are needed for the rest: the exact settle boundary, a leak run counting once, saturation after hundreds of events, and a clear that coincides with a new event. A cycle-by-cycle model in the bench compares every output on every cycle throughout.

// File: rtl/iso_mon_pkg.sv
package iso_mon_pkg;
  localparam int NCLS  = 4;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    CL_LATE  = 2'd0,
    CL_EARLY = 2'd1,
    CL_DROP  = 2'd2,
    CL_LEAK  = 2'd3
  } err_cls_e;
endpackage

// File: rtl/iso_mon_settle.sv
module iso_mon_settle #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_en_i,
  input  logic pwr_ack_i,
  output logic ready_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] LIMIT = SW'(SETTLE_CYC);

  logic [SW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!(pwr_en_i && pwr_ack_i)) begin
      run_q <= '0;
    end else if (run_q != LIMIT) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign ready_o = (run_q == LIMIT);

  // losing power or acknowledge removes readiness on the next cycle
  p_ready_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_en_i && pwr_ack_i) |=> !ready_o);
endmodule

// File: rtl/iso_mon_detect.sv
module iso_mon_detect
  import iso_mon_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [DATA_W-1:0] CLAMP_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iso_en_i,
  input  logic            pwr_en_i,
  input  logic            ready_i,
  input  logic [DATA_W-1:0] iso_out_i,
  output logic [NCLS-1:0] evt_o
);
  logic primed_q;
  logic pwr_q;
  logic iso_q;
  logic mis_q;
  logic mis_now;
  logic iso_fell;
  logic pwr_fell;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      pwr_q    <= 1'b0;
      iso_q    <= 1'b0;
      mis_q    <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      pwr_q    <= pwr_en_i;
      iso_q    <= iso_en_i;
      mis_q    <= mis_now;
    end
  end

  assign mis_now  = primed_q && !pwr_en_i && (iso_out_i != CLAMP_VAL);
  assign iso_fell = primed_q && iso_q && !iso_en_i;
  assign pwr_fell = primed_q && pwr_q && !pwr_en_i;

  always_comb begin
    evt_o           = '0;
    evt_o[CL_LATE]  = pwr_fell && !iso_en_i;
    evt_o[CL_EARLY] = iso_fell && pwr_en_i && !ready_i;
    evt_o[CL_DROP]  = iso_fell && !pwr_en_i;
    evt_o[CL_LEAK]  = mis_now && !mis_q;
  end

  p_late_r2: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q && $fell(pwr_en_i) && !iso_en_i |-> evt_o[CL_LATE]);
  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q && $fell(iso_en_i) && !pwr_en_i |-> evt_o[CL_DROP]);
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_o[CL_EARLY], evt_o[CL_DROP]}));
  p_leak_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o[CL_LEAK] |=> !evt_o[CL_LEAK]);
endmodule

// File: rtl/iso_mon_log.sv
module iso_mon_log
  import iso_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             evt_i,
  output logic             flag_o,
  output logic             pulse_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o  <= 1'b0;
      pulse_o <= 1'b0;
      cnt_o   <= '0;
    end else begin
      pulse_o <= evt_i;
      if (clr_i) begin
        flag_o <= evt_i;
        cnt_o  <= evt_i ? CNT_W'(1) : '0;
      end else begin
        if (evt_i) flag_o <= 1'b1;
        if (evt_i && cnt_o != CMAX) cnt_o <= cnt_o + 1'b1;
      end
    end
  end

  p_pulse_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> flag_o);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !clr_i |=> flag_o);
  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o == CMAX && !clr_i |=> cnt_o == CMAX);
  p_flag_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o == (cnt_o != '0));
endmodule

// File: rtl/iso_order_mon.sv
module iso_order_mon
  import iso_mon_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] CLAMP_VAL  = '0,
  parameter int                SETTLE_CYC = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   iso_en_i,
  input  logic                   pwr_en_i,
  input  logic                   pwr_ack_i,
  input  logic [DATA_W-1:0]      iso_out_i,
  input  logic                   clr_i,
  output logic [NCLS-1:0]        err_flags_o,
  output logic [NCLS-1:0]        err_pulse_o,
  output logic [NCLS*CNT_W-1:0]  err_cnt_o
);
  logic            ready;
  logic [NCLS-1:0] evt;

  iso_mon_settle #(.SETTLE_CYC(SETTLE_CYC)) settle_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_en_i  (pwr_en_i),
    .pwr_ack_i (pwr_ack_i),
    .ready_o   (ready)
  );

  iso_mon_detect #(.DATA_W(DATA_W), .CLAMP_VAL(CLAMP_VAL)) detect_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .iso_en_i  (iso_en_i),
    .pwr_en_i  (pwr_en_i),
    .ready_i   (ready),
    .iso_out_i (iso_out_i),
    .evt_o     (evt)
  );

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    iso_mon_log log_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr_i),
      .evt_i   (evt[k]),
      .flag_o  (err_flags_o[k]),
      .pulse_o (err_pulse_o[k]),
      .cnt_o   (err_cnt_o[k*CNT_W +: CNT_W])
    );
  end

  // an ordered release after settling never flags early
  p_settled_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready && pwr_en_i |-> !evt[CL_EARLY]);
endmodule

// File: tb/iso_order_mon_tb_top.sv
module iso_order_mon_tb_top;
  localparam int SETTLE = 4;
  logic clk = 0, rst_n = 0;
  logic iso_en = 1, pwr_en = 0, pwr_ack = 0, clr = 0;
  logic [7:0] iso_out = 8'h00;
  logic [3:0] flags, pulses;
  logic [31:0] cnts;
  int n_chk = 0, n_fail = 0, cyc = 0;

  iso_order_mon #(.DATA_W(8), .CLAMP_VAL(8'h00), .SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .iso_en_i(iso_en), .pwr_en_i(pwr_en),
    .pwr_ack_i(pwr_ack), .iso_out_i(iso_out), .clr_i(clr),
    .err_flags_o(flags), .err_pulse_o(pulses), .err_cnt_o(cnts));

  always #10 clk = ~clk;

  // behavioural reference model
  int mflag[4], mpulse[4], mcnt[4];
  int primed = 0, ackrun = 0, ppwr = 0, piso = 0, pmis = 0;
  always @(posedge clk) begin
    int ev[4];
    int mis, rdy;
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin mflag[k] = 0; mpulse[k] = 0; mcnt[k] = 0; end
      primed = 0; ackrun = 0; ppwr = 0; piso = 0; pmis = 0;
    end else begin
      rdy = (ackrun >= SETTLE);
      mis = primed && !pwr_en && (iso_out != 8'h00);
      ev[0] = primed && ppwr && !pwr_en && !iso_en;
      ev[1] = primed && piso && !iso_en && pwr_en && !rdy;
      ev[2] = primed && piso && !iso_en && !pwr_en;
      ev[3] = mis && !pmis;
      for (int k = 0; k < 4; k++) begin
        mpulse[k] = ev[k];
        if (clr) begin mflag[k] = ev[k]; mcnt[k] = ev[k]; end
        else if (ev[k]) begin mflag[k] = 1; if (mcnt[k] < 255) mcnt[k]++; end
      end
      ackrun = (pwr_en && pwr_ack) ? ((ackrun < SETTLE) ? ackrun + 1 : SETTLE) : 0;
      primed = 1; ppwr = pwr_en; piso = iso_en; pmis = mis;
    end
  end

  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < 4; k++) begin
      n_chk++;
      if (flags[k] !== 1'(mflag[k]) || pulses[k] !== 1'(mpulse[k]) ||
          cnts[k*8 +: 8] !== 8'(mcnt[k])) begin
        n_fail++;
        $display("FAIL R6/R7/R8 model class %0d: flag %b pulse %b cnt %0d exp %0d %0d %0d",
                 k, flags[k], pulses[k], cnts[k*8 +: 8], mflag[k], mpulse[k], mcnt[k]);
      end
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    tick(3);
    chk("R1 reset flags", {28'h0, flags}, 0);
    chk("R1 reset counters", cnts, 0);
    rst_n = 1;
    tick(1);
    chk("R1 first edge quiet", {24'h0, flags, pulses}, 0);
    // R9 ordered power-up then power-down
    pwr_en = 1; tick(1);
    pwr_ack = 1; tick(SETTLE + 1);
    iso_en = 0; tick(1);
    chk("R9 release after settle", {28'h0, flags}, 0);
    tick(3);
    iso_en = 1; tick(2);
    pwr_en = 0; pwr_ack = 0; tick(2);
    chk("R9 ordered off", {28'h0, flags}, 0);
    // R2 late isolation: power up, release, then switch off without isolation
    pwr_en = 1; pwr_ack = 1; tick(SETTLE + 2);
    iso_en = 0; tick(2);
    pwr_en = 0; pwr_ack = 0; tick(1);
    chk("R2 late pulse", {28'h0, pulses}, 4'b0001);
    chk("R2 late flag", {28'h0, flags}, 4'b0001);
    tick(1);
    chk("R7 pulse single cycle", {28'h0, pulses}, 0);
    iso_en = 1; tick(2);
    // R6 clear
    clr = 1; tick(1); clr = 0;
    chk("R6 clear flags", {28'h0, flags}, 0);
    chk("R6 clear counters", cnts, 0);
    // R3 early release: ack only 2 edges
    pwr_en = 1; pwr_ack = 1; tick(2);
    iso_en = 0; tick(1);
    chk("R3 early flag", {28'h0, flags}, 4'b0010);
    chk("R3 early count", {24'h0, cnts[15:8]}, 1);
    iso_en = 1; tick(2);
    // R3 boundary: SETTLE-1 edges is still early, go off first
    pwr_en = 0; pwr_ack = 0; tick(2);
    pwr_en = 1; pwr_ack = 1; tick(SETTLE - 1);
    iso_en = 0; tick(1);
    chk("R3 boundary early", {24'h0, cnts[15:8]}, 2);
    iso_en = 1; tick(2);
    pwr_en = 0; pwr_ack = 0; tick(2);
    pwr_en = 1; pwr_ack = 1; tick(SETTLE);
    iso_en = 0; tick(1);
    chk("R3 boundary settled", {24'h0, cnts[15:8]}, 2);
    iso_en = 1; tick(2);
    pwr_en = 0; pwr_ack = 0; tick(2);
    // R4 drop while off
    iso_en = 0; tick(1);
    chk("R4 drop flag", {31'h0, flags[2]}, 1);
    chk("R4 drop not early", {24'h0, cnts[15:8]}, 2);
    iso_en = 1; tick(2);
    // R5 leak run counts once
    iso_out = 8'h5A; tick(3);
    chk("R5 leak once", {24'h0, cnts[31:24]}, 1);
    iso_out = 8'h00; tick(1);
    iso_out = 8'h01; tick(1);
    chk("R5 leak second", {24'h0, cnts[31:24]}, 2);
    iso_out = 8'h00; tick(1);
    // R5 mismatch with power on is not a leak
    pwr_en = 1; tick(1); iso_out = 8'hFF; tick(2);
    chk("R5 powered no leak", {24'h0, cnts[31:24]}, 2);
    iso_out = 8'h00; tick(1); pwr_en = 0; tick(2);
    // R8 saturation
    for (int i = 0; i < 300; i++) begin
      iso_out = 8'h5A; tick(1); iso_out = 8'h00; tick(1);
    end
    chk("R8 saturate", {24'h0, cnts[31:24]}, 255);
    // R6 clear coincident with event
    clr = 1; iso_out = 8'h33; tick(1); clr = 0;
    chk("R6 clear with event flag", {28'h0, flags}, 4'b1000);
    chk("R6 clear with event cnt", cnts, 32'h0100_0000);
    iso_out = 8'h00; tick(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule